// File: doc/BRIEF.md
# DC-Link Squared-Voltage Disturbance-Rejection Regulator

This block is the outer voltage loop of a grid-tied converter. Each time a sample strobe arrives, it takes the measured DC-link voltage and its setpoint and squares both. It then runs one step of a first-order linear active disturbance rejection controller. Working on the square of the voltage makes the link dynamics linear in power. The regulator's output is an active-power reference for a faster inner power loop.

Two estimates are held as fixed-point state. The first tracks the squared voltage. The second tracks the lumped disturbance, meaning every effect the nominal gain does not explain. The control law applies proportional feedback on the estimated tracking error, subtracts the disturbance estimate and multiplies by a precomputed reciprocal of the nominal plant gain. It then clamps the result to a symmetric power limit. The observer is advanced by a forward-Euler step that uses the clamped output.

Gains are supplied already multiplied by the sample period:
- the first observer gain is 2ωo·Ts;
- the second observer gain is ωo²·Ts²;
- the control gain is ωc·Ts;
- the nominal gain is b0·Ts;
- the reciprocal is 1/(b0·Ts).

With ωc = 100 rad/s, ωo = 500 rad/s, b0 = −0.0005 and Ts = 100 µs, these values are 6554, 164, 655 (all in Q16), −54976 (scaled by 2^40) and −1310720000000 (Q16).

A sequencer with four states handles each accepted sample:
- ST_IDLE captures the inputs when sample_i is high, then goes to ST_SQUARE.
- ST_SQUARE registers the two squares, then goes to ST_LAW.
- ST_LAW computes and clamps the power reference, then goes to ST_UPDATE.
- ST_UPDATE advances the observer, then returns to ST_IDLE.

Top module: `dclink_adrc`

## Requirements
- R1: The measured and reference squares are formed as Y = vdc_i² · 2^16 and R = vref_i² · 2^16. Both estimates z1 and z2 carry 16 fractional bits.
- R2: sample_i is accepted only at a clock edge where the sequencer is in ST_IDLE. valid_o is high for exactly one cycle, after the third rising edge counted from the accepting edge. p_ref_o changes only when valid_o rises and otherwise holds its value.
- R3: A high sample_i seen during ST_SQUARE, ST_LAW or ST_UPDATE has no effect. Accepted samples are therefore at least four cycles apart.
- R4: The raw output is u = floor(((floor(k_ctl·(R − z1) / 2^16)) − z2) · k_inv / 2^32). Every shift is arithmetic and rounds toward minus infinity.
- R5: p_ref_o is u clamped to the range −p_lim_i to +p_lim_i, with p_lim_i held constant.
- R6: The first estimate is updated as z1' = sat(z1 + floor(k_obs1·(Y − z1)/2^16) + z2 + floor(k_b0·p/2^24)). Here p is the clamped output of the same sample and z2 is its value before the update.
- R7: The second estimate is updated as z2' = sat(z2 + floor(k_obs2·(Y − z1)/2^16)). Both estimates change exactly once per accepted sample, in ST_UPDATE.
- R8: sat() limits each estimate to the signed 44-bit range −2^43 to 2^43 − 1.
- R9: While rst is high at a clock edge, z1 loads the live square of vdc_i, z2 clears, p_ref_o is 0 and valid_o is 0. As a result, a sample taken at the reset voltage with an equal reference yields 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sample_i | input | 1 | Start-of-sample strobe |
| vdc_i | input | 12 | Measured DC-link voltage, unsigned integer volts |
| vref_i | input | 12 | DC-link voltage setpoint, unsigned integer volts |
| k_obs1_i | input | 24 | First observer gain 2ωo·Ts, signed Q16 |
| k_obs2_i | input | 24 | Second observer gain ωo²·Ts², signed Q16 |
| k_ctl_i | input | 24 | Control gain ωc·Ts, signed Q16 |
| k_b0_i | input | 24 | Nominal gain b0·Ts, signed, scaled by 2^40 |
| k_inv_i | input | 48 | Reciprocal 1/(b0·Ts), signed Q16 |
| p_lim_i | input | 31 | Magnitude of the power clamp |
| p_ref_o | output | 32 | Signed active-power reference |
| valid_o | output | 1 | One-cycle strobe marking a new p_ref_o |

## Verification
The assertions assume that the gains and p_lim_i hold steady while a sample is in flight. They also assume that sample_i is a defined level at every edge, and that reset lasts long enough for z1 to settle on a defined voltage. The bench changes gains and the limit only around a reset. It holds vdc_i constant through each reset and drives every input half a cycle away from the rising edge. Its only deliberately out-of-pattern stimulus is a strobe held high across a busy sequence, which exercises the rule that such a strobe is ignored.

// File: rtl/dclink_adrc_pkg.sv
package dclink_adrc_pkg;
    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SQUARE,
        ST_LAW,
        ST_UPDATE
    } adrc_state_e;
endpackage

// File: rtl/adrc_squarer.sv
module adrc_squarer #(
    parameter int VW = 12,
    parameter int SF = 16,
    parameter int ZW = 44
) (
    input  logic [VW-1:0]        v_i,
    output logic signed [ZW-1:0] sq_o
);
    localparam int DW = 2 * VW;

    logic [DW-1:0] prod;

    always_comb begin
        prod = DW'(v_i) * DW'(v_i);
        sq_o = $signed(ZW'(prod) << SF);
    end
endmodule

// File: rtl/adrc_law.sv
module adrc_law #(
    parameter int ZW = 44,
    parameter int KW = 24,
    parameter int IW = 48,
    parameter int PW = 32,
    parameter int SF = 16,
    parameter int KF = 16
) (
    input  logic signed [ZW-1:0] r_i,
    input  logic signed [ZW-1:0] z1_i,
    input  logic signed [ZW-1:0] z2_i,
    input  logic signed [KW-1:0] k_ctl_i,
    input  logic signed [IW-1:0] k_inv_i,
    input  logic [PW-2:0]        p_lim_i,
    output logic signed [PW-1:0] u_o
);
    localparam int WW = ZW + KW + IW + 4;

    logic signed [WW-1:0] err, fb, num, raw, lim;

    always_comb begin
        err = WW'(r_i) - WW'(z1_i);
        fb  = (WW'(k_ctl_i) * err) >>> KF;
        num = fb - WW'(z2_i);
        raw = (num * WW'(k_inv_i)) >>> (SF + KF);
        lim = WW'($signed({1'b0, p_lim_i}));
        if (raw > lim) begin
            u_o = lim[PW-1:0];
        end else if (raw < -lim) begin
            u_o = PW'(-lim);
        end else begin
            u_o = raw[PW-1:0];
        end
    end
endmodule

// File: rtl/adrc_observer.sv
module adrc_observer #(
    parameter int ZW = 44,
    parameter int KW = 24,
    parameter int PW = 32,
    parameter int SF = 16,
    parameter int KF = 16,
    parameter int BF = 40
) (
    input  logic signed [ZW-1:0] y_i,
    input  logic signed [ZW-1:0] z1_i,
    input  logic signed [ZW-1:0] z2_i,
    input  logic signed [PW-1:0] u_i,
    input  logic signed [KW-1:0] k_obs1_i,
    input  logic signed [KW-1:0] k_obs2_i,
    input  logic signed [KW-1:0] k_b0_i,
    output logic signed [ZW-1:0] z1_o,
    output logic signed [ZW-1:0] z2_o
);
    localparam int WW = ZW + KW + PW + 4;
    localparam logic signed [WW-1:0] ZMAX = WW'({1'b0, {(ZW-1){1'b1}}});
    localparam logic signed [WW-1:0] ZMIN = -ZMAX - 1;

    function automatic logic signed [ZW-1:0] clip(input logic signed [WW-1:0] v);
        if (v > ZMAX) begin
            return ZMAX[ZW-1:0];
        end else if (v < ZMIN) begin
            return ZMIN[ZW-1:0];
        end
        return v[ZW-1:0];
    endfunction

    logic signed [WW-1:0] err, inj;

    always_comb begin
        err  = WW'(y_i) - WW'(z1_i);
        inj  = (WW'(k_b0_i) * WW'(u_i)) >>> (BF - SF);
        z1_o = clip(WW'(z1_i) + ((WW'(k_obs1_i) * err) >>> KF) + WW'(z2_i) + inj);
        z2_o = clip(WW'(z2_i) + ((WW'(k_obs2_i) * err) >>> KF));
    end
endmodule

// File: rtl/dclink_adrc.sv
module dclink_adrc
    import dclink_adrc_pkg::*;
#(
    parameter int VW = 12,
    parameter int SF = 16,
    parameter int KF = 16,
    parameter int BF = 40,
    parameter int ZW = 44,
    parameter int KW = 24,
    parameter int IW = 48,
    parameter int PW = 32
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 sample_i,
    input  logic [VW-1:0]        vdc_i,
    input  logic [VW-1:0]        vref_i,
    input  logic signed [KW-1:0] k_obs1_i,
    input  logic signed [KW-1:0] k_obs2_i,
    input  logic signed [KW-1:0] k_ctl_i,
    input  logic signed [KW-1:0] k_b0_i,
    input  logic signed [IW-1:0] k_inv_i,
    input  logic [PW-2:0]        p_lim_i,
    output logic signed [PW-1:0] p_ref_o,
    output logic                 valid_o
);
    localparam int NSQ = 3;

    adrc_state_e state_q, state_d;

    logic [VW-1:0]        vm_q, vr_q;
    logic [VW-1:0]        sq_in  [NSQ];
    logic signed [ZW-1:0] sq_out [NSQ];
    logic signed [ZW-1:0] y_q, r_q, z1_q, z2_q, z1_n, z2_n;
    logic signed [PW-1:0] u_law;

    // squarer 0 seeds the estimate in reset; 1 and 2 serve the captured sample
    assign sq_in[0] = vdc_i;
    assign sq_in[1] = vm_q;
    assign sq_in[2] = vr_q;

    for (genvar g = 0; g < NSQ; g++) begin : g_sq
        adrc_squarer #(.VW(VW), .SF(SF), .ZW(ZW)) u_sq (
            .v_i  (sq_in[g]),
            .sq_o (sq_out[g])
        );
    end

    adrc_law #(.ZW(ZW), .KW(KW), .IW(IW), .PW(PW), .SF(SF), .KF(KF)) u_law_blk (
        .r_i     (r_q),
        .z1_i    (z1_q),
        .z2_i    (z2_q),
        .k_ctl_i (k_ctl_i),
        .k_inv_i (k_inv_i),
        .p_lim_i (p_lim_i),
        .u_o     (u_law)
    );

    adrc_observer #(.ZW(ZW), .KW(KW), .PW(PW), .SF(SF), .KF(KF), .BF(BF)) u_obs (
        .y_i      (y_q),
        .z1_i     (z1_q),
        .z2_i     (z2_q),
        .u_i      (p_ref_o),
        .k_obs1_i (k_obs1_i),
        .k_obs2_i (k_obs2_i),
        .k_b0_i   (k_b0_i),
        .z1_o     (z1_n),
        .z2_o     (z2_n)
    );

    always_ff @(posedge clk) begin
        if (rst) state_q <= ST_IDLE;
        else     state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_IDLE:   if (sample_i) state_d = ST_SQUARE;
            ST_SQUARE: state_d = ST_LAW;
            ST_LAW:    state_d = ST_UPDATE;
            ST_UPDATE: state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            z1_q <= sq_out[0];
            z2_q <= '0;
            vm_q <= '0;
            vr_q <= '0;
            y_q  <= '0;
            r_q  <= '0;
        end else begin
            unique case (state_q)
                ST_IDLE: if (sample_i) begin
                    vm_q <= vdc_i;
                    vr_q <= vref_i;
                end
                ST_SQUARE: begin
                    y_q <= sq_out[1];
                    r_q <= sq_out[2];
                end
                ST_UPDATE: begin
                    z1_q <= z1_n;
                    z2_q <= z2_n;
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            p_ref_o <= '0;
            valid_o <= 1'b0;
        end else begin
            valid_o <= (state_q == ST_LAW);
            if (state_q == ST_LAW) p_ref_o <= u_law;
        end
    end

    // R2: strobe lasts one cycle
    a_r2_valid_pulse: assert property (@(posedge clk) disable iff (rst)
        valid_o |=> !valid_o);
    // R2: a result follows an accepted strobe by three edges
    a_r2_valid_cause: assert property (@(posedge clk) disable iff (rst)
        $rose(valid_o) |-> $past(sample_i, 3));
    // R2: output holds between results
    a_r2_hold: assert property (@(posedge clk) disable iff (rst)
        !valid_o |-> $stable(p_ref_o));
    // R3: a strobe while busy does not restart the sequence
    a_r3_busy_ignored: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_IDLE) |=> (state_q != ST_SQUARE));
    // R5: published reference within the clamp
    a_r5_clamp: assert property (@(posedge clk) disable iff (rst)
        valid_o |-> (p_ref_o <= $signed({1'b0, p_lim_i}) && p_ref_o >= -$signed({1'b0, p_lim_i})));
    // R7: estimates move only in the update step
    a_r7_hold: assert property (@(posedge clk) disable iff (rst)
        (state_q != ST_UPDATE) |=> ($stable(z1_q) && $stable(z2_q)));
    // R9: reset state
    a_r9_reset: assert property (@(posedge clk)
        rst |=> (z2_q == '0 && p_ref_o == '0 && !valid_o && state_q == ST_IDLE));
endmodule

// File: tb/dclink_adrc_bench.sv
module dclink_adrc_bench;
    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic               rst = 1'b1;
    logic               sample = 1'b0;
    logic [11:0]        vdc = '0, vref = '0;
    logic signed [23:0] k_obs1, k_obs2, k_ctl, k_b0;
    logic signed [47:0] k_inv;
    logic [30:0]        p_lim;
    logic signed [31:0] p_ref;
    logic               valid;

    dclink_adrc u_dclink_adrc (
        .clk(clk), .rst(rst), .sample_i(sample), .vdc_i(vdc), .vref_i(vref),
        .k_obs1_i(k_obs1), .k_obs2_i(k_obs2), .k_ctl_i(k_ctl), .k_b0_i(k_b0),
        .k_inv_i(k_inv), .p_lim_i(p_lim), .p_ref_o(p_ref), .valid_o(valid)
    );

    int n_chk = 0, n_fail = 0, n_valid = 0;
    bit done = 0;
    logic signed [127:0] m_z1, m_z2;
    localparam logic signed [127:0] ZTOP = (128'sd1 <<< 43) - 1;
    localparam logic signed [127:0] ZBOT = -(128'sd1 <<< 43);

    always @(negedge clk) if (valid) n_valid++;

    function automatic logic signed [127:0] zsat(input logic signed [127:0] v);
        if (v > ZTOP) return ZTOP;
        if (v < ZBOT) return ZBOT;
        return v;
    endfunction

    task automatic check(input string req, input string what, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic set_gains(input int o1, input int o2, input int c, input int b0,
                             input longint inv, input longint lim);
        k_obs1 = 24'(o1); k_obs2 = 24'(o2); k_ctl = 24'(c); k_b0 = 24'(b0);
        k_inv = 48'(inv); p_lim = 31'(lim);
    endtask

    task automatic default_gains(input longint lim);
        set_gains(6554, 164, 655, -54976, -64'sd1310720000000, lim);
    endtask

    task automatic do_reset(input int v);
        @(negedge clk);
        rst = 1'b1; sample = 1'b0; vdc = 12'(v);
        repeat (3) @(negedge clk);
        rst = 1'b0;
        m_z1 = 128'(v * v) <<< 16;
        m_z2 = '0;
    endtask

    task automatic model_step(input int vm, input int vr, output longint u);
        logic signed [127:0] y, r, fb, raw, lim, uc, e, n1, n2;
        y   = 128'(vm * vm) <<< 16;
        r   = 128'(vr * vr) <<< 16;
        fb  = (128'(k_ctl) * (r - m_z1)) >>> 16;
        raw = ((fb - m_z2) * 128'(k_inv)) >>> 32;
        lim = 128'(p_lim);
        uc  = (raw > lim) ? lim : ((raw < -lim) ? -lim : raw);
        e   = y - m_z1;
        n1  = zsat(m_z1 + ((128'(k_obs1) * e) >>> 16) + m_z2 + ((128'(k_b0) * uc) >>> 24));
        n2  = zsat(m_z2 + ((128'(k_obs2) * e) >>> 16));
        m_z1 = n1; m_z2 = n2;
        u = longint'(uc);
    endtask

    // starts and ends just after a falling edge
    task automatic run(input int vm, input int vr, input string req, output longint u);
        vdc = 12'(vm); vref = 12'(vr); sample = 1'b1;
        @(negedge clk); sample = 1'b0;
        repeat (2) @(negedge clk);
        model_step(vm, vr, u);
        check(req, "valid at result", longint'(valid), 1);
        check(req, "p_ref", longint'(p_ref), u);
        @(negedge clk);
    endtask

    task automatic t_reset_state;
        default_gains(64'h7fffffff);
        do_reset(700);
        check("R9", "p_ref after reset", longint'(p_ref), 0);
        check("R9", "valid after reset", longint'(valid), 0);
    endtask

    task automatic t_squares;
        longint u;
        set_gains(0, 0, 65536, 0, 65536, 64'h7fffffff);
        do_reset(100);
        run(100, 3000, "R1", u);
        check("R1", "square difference 3000/100", longint'(p_ref), 8990000);
        run(100, 2000, "R4", u);
        check("R4", "square difference 2000/100", longint'(p_ref), 3990000);
    endtask

    task automatic t_latency;
        longint u;
        default_gains(64'h7fffffff);
        do_reset(700);
        vdc = 12'd700; vref = 12'd701; sample = 1'b1;
        @(negedge clk); sample = 1'b0;
        check("R2", "valid one edge after accept", longint'(valid), 0);
        @(negedge clk);
        check("R2", "valid two edges after accept", longint'(valid), 0);
        @(negedge clk);
        model_step(700, 701, u);
        check("R2", "valid three edges after accept", longint'(valid), 1);
        check("R4", "p_ref small error", longint'(p_ref), u);
        @(negedge clk);
        check("R2", "valid drops after one cycle", longint'(valid), 0);
        check("R2", "p_ref holds", longint'(p_ref), u);
    endtask

    task automatic t_equilibrium;
        longint u;
        default_gains(64'h7fffffff);
        do_reset(700);
        for (int i = 0; i < 3; i++) begin
            run(700, 700, "R9", u);
            check("R9", "equilibrium output", longint'(p_ref), 0);
        end
    endtask

    task automatic t_ref_step;
        longint u;
        default_gains(64'h7fffffff);
        do_reset(700);
        for (int i = 0; i < 6; i++) run(700 + (i > 2 ? 1 : 0), 701, "R6", u);
    endtask

    task automatic t_disturbance;
        longint u;
        default_gains(64'h7fffffff);
        do_reset(700);
        for (int i = 0; i < 8; i++) run(700 - (i < 5 ? i : 8 - i), 700, "R7", u);
    endtask

    task automatic t_clamp;
        longint u;
        default_gains(100000);
        do_reset(700);
        run(700, 701, "R5", u);
        check("R5", "negative clamp", longint'(p_ref), -100000);
        run(700, 701, "R6", u);
        default_gains(100000);
        do_reset(700);
        run(700, 699, "R5", u);
        check("R5", "positive clamp", longint'(p_ref), 100000);
    endtask

    task automatic t_busy;
        longint u;
        int snap;
        default_gains(64'h7fffffff);
        do_reset(700);
        snap = n_valid;
        vdc = 12'd700; vref = 12'd701; sample = 1'b1;
        repeat (3) @(negedge clk);
        sample = 1'b0;
        model_step(700, 701, u);
        check("R3", "result under held strobe", longint'(p_ref), u);
        repeat (6) @(negedge clk);
        check("R3", "one result for held strobe", longint'(n_valid - snap), 1);
        run(702, 701, "R3", u);
    endtask

    task automatic t_saturation;
        longint u;
        set_gains(0, 8388607, 0, 0, 65536, 64'h7fffffff);
        do_reset(4095);
        run(0, 0, "R8", u);
        check("R8", "first output zero", longint'(p_ref), 0);
        run(0, 0, "R8", u);
        check("R8", "output from saturated estimate", longint'(p_ref), 134217728);
    endtask

    initial begin
        t_reset_state();
        t_squares();
        t_latency();
        t_equilibrium();
        t_ref_step();
        t_disturbance();
        t_clamp();
        t_busy();
        t_saturation();
        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL R2 watchdog actual=hung expected=finished");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule